// File: doc/BRIEF.md
# Two-Wire Register Slave with Pointer Selection

This block is a target on a two-wire serial bus (SCL clock, SDA open-drain data). An external controller addresses it with a 7-bit address made of a fixed 4-bit prefix (a parameter) and three strap inputs, which supply the low address bits. A write transaction carries a pointer byte first. The two low bits of that byte pick one of four internal registers, and any bytes that follow are data for that register. A read transaction returns the contents of the register the pointer currently selects.

Both bus lines pass through a two-flop synchronizer into the system clock domain. START, repeated START and STOP are detected from the synchronized values. The block never drives SDA high. Its only bus output is a pull-low enable, and the surrounding pad logic ties that enable to the open-drain SDA line. The three writable registers appear on output ports. The temperature register is a read-only view of an input port. The system clock must run at least eight times faster than SCL.

Top module: `twreg_slave`

## Requirements
- R1: After reset the block does not pull SDA low. The configuration output is 0x00, the low threshold equals LOW_INIT (default 0x4B00) and the high threshold equals HIGH_INIT (default 0x5000). The stored pointer is 00.
- R2: The first byte after a START is sent MSB first: seven address bits, then the direction bit (1 = read). If the address equals {DEV_PREFIX, strapAddr} (default prefix 4'b1001), the block acknowledges by pulling SDA low for the ninth clock. Otherwise it does not acknowledge, and it leaves SDA released until the next START or STOP.
- R3: In a write, the first byte after the address is the pointer byte, and it is always acknowledged. Its two low bits select the register: 00 temperature, 01 configuration, 10 low threshold, 11 high threshold. Its six upper bits are ignored.
- R4: Each data byte of a write is acknowledged. For the two 16-bit thresholds, the first data byte goes to bits 15:8 and the second to bits 7:0, each stored as soon as it completes. The 8-bit configuration register takes only the first data byte. Any further bytes are acknowledged and discarded.
- R5: A write to pointer 00 is acknowledged and changes no register.
- R6: Read data is sent MSB first. A 16-bit register is sent high byte first, and further bytes alternate high, low, high and so on. The configuration register repeats its single byte. Pointer 00 returns sensorValue. SDA changes only while SCL is low.
- R7: A read that has no pointer write in the same transaction uses the last stored pointer. After reset that pointer is 00.
- R8: When the controller leaves SDA high on the acknowledge clock of a read byte, the block stops sending and keeps SDA released until the next START or STOP.
- R9: A repeated START after a pointer write begins a new transaction, and a read in that transaction uses the new pointer.
- R10: A STOP in the middle of a data byte discards the partial byte, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaDriveLow | output | 1 | When 1, the pad pulls SDA low |
| strapAddr | input | 3 | Strap pins forming address bits 2:0 |
| sensorValue | input | 16 | Value returned for pointer 00 |
| cfgOut | output | 8 | Configuration register |
| lowThresh | output | 16 | Low threshold register |
| highThresh | output | 16 | High threshold register |

## Verification
The bench targets the edges of the transaction. It sends an address that differs only in a strap bit, and a mis-decoded strap would show up as a wrong acknowledge or as SDA being pulled low during bytes meant for another device. It also sends a pointer byte with its upper bits set, and a design that decodes those bits would select the wrong register or refuse the byte. It writes three bytes to the configuration register and to a threshold, a write to the temperature pointer, and a STOP inside a data byte, each of which catches a design that stores bytes it should discard. It also runs reads longer than the register, which expose a pointer that auto-increments or a wrong byte order, and a controller NACK, after which a faulty block would keep driving data bits.

// File: rtl/twreg_pkg.sv
package twreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WDATA,
    ST_SACK,
    ST_RDATA,
    ST_MACK,
    ST_IGNORE
  } twState_t;

  typedef enum logic [1:0] {
    SEL_TEMP = 2'b00,
    SEL_CFG  = 2'b01,
    SEL_LOW  = 2'b10,
    SEL_HIGH = 2'b11
  } regSel_t;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic ptrLoad;
    logic dataWrite;
    logic lowHalf;
  } twStrobe_t;

endpackage

// File: rtl/twreg_ctrl.sv
module twreg_ctrl
  import twreg_pkg::*;
#(
  parameter int PREFIX_W = 4,
  parameter int STRAP_W = 3,
  parameter int BYTE_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [PREFIX_W-1:0] DEV_PREFIX = 4'b1001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] strapAddr,
  input  logic [BYTE_W-1:0]  rdByte,
  output twStrobe_t          strobe,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               sdaDriveLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclS, sdaS;
  logic sclRise, sclFall, startCond, stopCond, byteDone, addrHit;

  twState_t state, afterAck;
  logic [CNT_W-1:0] bitCnt;
  logic [BYTE_W-1:0] rxShift, txShift;
  logic [1:0] byteCnt;
  logic nackSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[SYNC_STAGES-2:0], sclIn};
      sdaSync <= {sdaSync[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclS = sclSync[SYNC_STAGES-1];
  assign sdaS = sdaSync[SYNC_STAGES-1];
  assign sclRise = sclS & ~sclPrev;
  assign sclFall = ~sclS & sclPrev;
  assign startCond = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopCond = sclS & sclPrev & ~sdaPrev & sdaS;
  assign byteDone = (bitCnt == CNT_W'(BYTE_W));
  assign addrHit = (rxShift[BYTE_W-1:1] == {DEV_PREFIX, strapAddr});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt <= '0;
      rxShift <= '0;
      txShift <= '1;
      byteCnt <= '0;
      nackSeen <= 1'b0;
    end else if (startCond) begin
      state <= ST_ADDR;
      bitCnt <= '0;
    end else if (stopCond) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (sclRise && !byteDone) begin
            rxShift <= {rxShift[BYTE_W-2:0], sdaS};
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall && byteDone) begin
            bitCnt <= '0;
            if (state == ST_ADDR) begin
              if (addrHit) begin
                state <= ST_SACK;
                afterAck <= rxShift[0] ? ST_RDATA : ST_PTR;
                byteCnt <= '0;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              state <= ST_SACK;
              afterAck <= ST_WDATA;
              if (state == ST_WDATA && byteCnt != 2'd2) byteCnt <= byteCnt + 1'b1;
            end
          end
        end
        ST_SACK: begin
          if (sclFall) begin
            state <= afterAck;
            bitCnt <= '0;
            if (afterAck == ST_RDATA) txShift <= rdByte;
          end
        end
        ST_RDATA: begin
          if (sclRise) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (sclFall) begin
            if (byteDone) begin
              state <= ST_MACK;
              byteCnt <= byteCnt + 1'b1;
            end else begin
              txShift <= {txShift[BYTE_W-2:0], 1'b1};
            end
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            nackSeen <= sdaS;
          end else if (sclFall) begin
            bitCnt <= '0;
            if (nackSeen) begin
              state <= ST_IGNORE;
            end else begin
              state <= ST_RDATA;
              txShift <= rdByte;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign strobe.ptrLoad = (state == ST_PTR) && sclFall && byteDone;
  assign strobe.dataWrite = (state == ST_WDATA) && sclFall && byteDone && (byteCnt != 2'd2);
  assign strobe.lowHalf = byteCnt[0];
  assign rxByte = rxShift;
  assign sdaDriveLow = (state == ST_SACK) || ((state == ST_RDATA) && !txShift[BYTE_W-1]);

endmodule

// File: rtl/twreg_datapath.sv
module twreg_datapath
  import twreg_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter logic [2*BYTE_W-1:0] LOW_INIT = 16'h4B00,
  parameter logic [2*BYTE_W-1:0] HIGH_INIT = 16'h5000
) (
  input  logic                clk,
  input  logic                rstN,
  input  twStrobe_t           strobe,
  input  logic [BYTE_W-1:0]   rxByte,
  input  logic [2*BYTE_W-1:0] sensorValue,
  output logic [BYTE_W-1:0]   rdByte,
  output logic [BYTE_W-1:0]   cfgOut,
  output logic [2*BYTE_W-1:0] lowThresh,
  output logic [2*BYTE_W-1:0] highThresh
);
  localparam int REG_W = 2 * BYTE_W;

  regSel_t ptr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= SEL_TEMP;
      cfgOut <= '0;
      lowThresh <= LOW_INIT;
      highThresh <= HIGH_INIT;
    end else begin
      if (strobe.ptrLoad) ptr <= regSel_t'(rxByte[1:0]);
      if (strobe.dataWrite) begin
        case (ptr)
          SEL_CFG: if (!strobe.lowHalf) cfgOut <= rxByte;
          SEL_LOW:
            if (strobe.lowHalf) lowThresh[BYTE_W-1:0] <= rxByte;
            else lowThresh[REG_W-1 -: BYTE_W] <= rxByte;
          SEL_HIGH:
            if (strobe.lowHalf) highThresh[BYTE_W-1:0] <= rxByte;
            else highThresh[REG_W-1 -: BYTE_W] <= rxByte;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [BYTE_W-1:0] halfOf(input logic [REG_W-1:0] v, input logic lo);
    return lo ? v[BYTE_W-1:0] : v[REG_W-1 -: BYTE_W];
  endfunction

  always_comb begin
    case (ptr)
      SEL_TEMP: rdByte = halfOf(sensorValue, strobe.lowHalf);
      SEL_CFG:  rdByte = cfgOut;
      SEL_LOW:  rdByte = halfOf(lowThresh, strobe.lowHalf);
      default:  rdByte = halfOf(highThresh, strobe.lowHalf);
    endcase
  end

endmodule

// File: rtl/twreg_slave.sv
module twreg_slave
  import twreg_pkg::*;
#(
  parameter logic [3:0] DEV_PREFIX = 4'b1001,
  parameter logic [15:0] LOW_INIT = 16'h4B00,
  parameter logic [15:0] HIGH_INIT = 16'h5000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaDriveLow,
  input  logic [2:0]  strapAddr,
  input  logic [15:0] sensorValue,
  output logic [7:0]  cfgOut,
  output logic [15:0] lowThresh,
  output logic [15:0] highThresh
);
  localparam int BYTE_W = 8;

  twStrobe_t strobe;
  logic [BYTE_W-1:0] rxByte, rdByte;

  twreg_ctrl #(
    .PREFIX_W(4), .STRAP_W(3), .BYTE_W(BYTE_W), .SYNC_STAGES(2), .DEV_PREFIX(DEV_PREFIX)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .strapAddr(strapAddr),
    .rdByte(rdByte), .strobe(strobe), .rxByte(rxByte), .sdaDriveLow(sdaDriveLow)
  );

  twreg_datapath #(
    .BYTE_W(BYTE_W), .LOW_INIT(LOW_INIT), .HIGH_INIT(HIGH_INIT)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte), .sensorValue(sensorValue),
    .rdByte(rdByte), .cfgOut(cfgOut), .lowThresh(lowThresh), .highThresh(highThresh)
  );

endmodule

// File: rtl/twreg_checker.sv
module twreg_checker #(
  parameter logic [15:0] LOW_INIT = 16'h4B00,
  parameter logic [15:0] HIGH_INIT = 16'h5000
) (
  input logic        clk,
  input logic        rstN,
  input logic        sclIn,
  input logic        sdaDriveLow,
  input logic [7:0]  cfgOut,
  input logic [15:0] lowThresh,
  input logic [15:0] highThresh
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rstN |=> (!sdaDriveLow && cfgOut == 8'h00 && lowThresh == LOW_INIT && highThresh == HIGH_INIT));

  assert_sda_moves_while_scl_low_R6: assert property (@(posedge clk) disable iff (!rstN)
    $changed(sdaDriveLow) |-> !sclIn);

  assert_cfg_written_while_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    $changed(cfgOut) |-> !sclIn);

  assert_thresh_written_while_scl_low_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($changed(lowThresh) || $changed(highThresh)) |-> !sclIn);

endmodule

bind twreg_slave twreg_checker #(.LOW_INIT(LOW_INIT), .HIGH_INIT(HIGH_INIT)) uChk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaDriveLow(sdaDriveLow),
  .cfgOut(cfgOut), .lowThresh(lowThresh), .highThresh(highThresh)
);

// File: tb/twreg_slave_test.sv
`timescale 1ns/1ps
module twreg_slave_test;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [6:0] DEV = {4'b1001, STRAP};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaDriveLow;
  logic [15:0] sensorValue = 16'h1234;
  logic [7:0] cfgOut;
  logic [15:0] lowThresh, highThresh;
  wire sdaBus = mSda & ~sdaDriveLow;

  int nChecks = 0, nFails = 0, driveViol = 0;
  logic watchNoDrive = 1'b0;
  logic finished = 1'b0;

  logic [1:0] mPtr = 2'b00;
  logic [7:0] mCfg = 8'h00;
  logic [15:0] mLow = 16'h4B00, mHigh = 16'h5000;

  always #5 clk = ~clk;

  twreg_slave uut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .sdaDriveLow(sdaDriveLow),
    .strapAddr(STRAP), .sensorValue(sensorValue), .cfgOut(cfgOut),
    .lowThresh(lowThresh), .highThresh(highThresh)
  );

  always @(negedge clk) if (watchNoDrive && sdaDriveLow) driveViol++;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    tick(10); mSda = 1'b1; tick(10); mScl = 1'b1; tick(20); mSda = 1'b0; tick(20); mScl = 1'b0;
  endtask

  task automatic busStop();
    tick(10); mSda = 1'b0; tick(10); mScl = 1'b1; tick(20); mSda = 1'b1; tick(20);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    tick(10); mSda = b; tick(10); mScl = 1'b1; tick(10); seen = sdaBus; tick(10); mScl = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(b[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input logic ackIt, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      b[i] = s;
    end
    clockBit(!ackIt, s);
  endtask

  function automatic logic [7:0] expectByte(input logic [1:0] p, input int k);
    logic lo = k[0];
    case (p)
      2'b00: return lo ? sensorValue[7:0] : sensorValue[15:8];
      2'b01: return mCfg;
      2'b10: return lo ? mLow[7:0] : mLow[15:8];
      default: return lo ? mHigh[7:0] : mHigh[15:8];
    endcase
  endfunction

  function automatic void modelWrite(input int k, input logic [7:0] b);
    if (k == 0) begin
      case (mPtr)
        2'b01: mCfg = b;
        2'b10: mLow[15:8] = b;
        2'b11: mHigh[15:8] = b;
        default: ;
      endcase
    end else if (k == 1) begin
      case (mPtr)
        2'b10: mLow[7:0] = b;
        2'b11: mHigh[7:0] = b;
        default: ;
      endcase
    end
  endfunction

  task automatic checkRegs(input string tag);
    check({tag, " cfg"}, {8'h00, cfgOut}, {8'h00, mCfg});
    check({tag, " low"}, lowThresh, mLow);
    check({tag, " high"}, highThresh, mHigh);
  endtask

  task automatic writeHead(input logic [7:0] ptrByte);
    logic a;
    busStart();
    sendByte({DEV, 1'b0}, a);
    check("R2 addr ack (write)", {15'd0, a}, 16'd1);
    sendByte(ptrByte, a);
    check("R3 pointer ack", {15'd0, a}, 16'd1);
    mPtr = ptrByte[1:0];
  endtask

  task automatic writeData(input int n, input logic [23:0] data);
    logic a;
    for (int k = 0; k < n; k++) begin
      sendByte(data[23 - 8*k -: 8], a);
      check("R4 data ack", {15'd0, a}, 16'd1);
      modelWrite(k, data[23 - 8*k -: 8]);
    end
  endtask

  task automatic readBody(input int n, input string tag);
    logic a;
    logic [7:0] b;
    sendByte({DEV, 1'b1}, a);
    check("R2 addr ack (read)", {15'd0, a}, 16'd1);
    for (int k = 0; k < n; k++) begin
      recvByte(k < n - 1, b);
      check(tag, {8'h00, b}, {8'h00, expectByte(mPtr, k)});
    end
    driveViol = 0;
    watchNoDrive = 1'b1;
    tick(10);
    busStop();
    watchNoDrive = 1'b0;
    check("R8 released after NACK", driveViol[15:0], 16'd0);
  endtask

  task automatic doWrite(input logic [7:0] ptrByte, input int n, input logic [23:0] data, input string tag);
    writeHead(ptrByte);
    writeData(n, data);
    busStop();
    checkRegs(tag);
  endtask

  task automatic doRead(input int n, input string tag);
    busStart();
    readBody(n, tag);
  endtask

  task automatic doPtrRead(input logic [7:0] ptrByte, input int n);
    writeHead(ptrByte);
    busStart();
    readBody(n, "R9 read after repeated START");
  endtask

  task automatic doWrongAddr(input logic [6:0] addr);
    logic a;
    driveViol = 0;
    watchNoDrive = 1'b1;
    busStart();
    sendByte({addr, 1'b0}, a);
    check("R2 no ack on mismatch", {15'd0, a}, 16'd0);
    sendByte(8'h01, a);
    sendByte(8'h00, a);
    busStop();
    watchNoDrive = 1'b0;
    check("R2 SDA never driven when unaddressed", driveViol[15:0], 16'd0);
    checkRegs("R2 registers untouched");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic s;
    void'($urandom(32'd20240611));
    tick(5);
    check("R1 no SDA drive in reset", {15'd0, sdaDriveLow}, 16'd0);
    rstN = 1'b1;
    tick(5);
    check("R1 SDA released", {15'd0, sdaDriveLow}, 16'd0);
    checkRegs("R1 reset values");

    // pointer resets to 00: read temperature without a pointer write
    sensorValue = 16'hA55A;
    doRead(3, "R7 default pointer reads sensor (R6 order)");

    // strap bit differs / prefix differs
    doWrongAddr(DEV ^ 7'b0000010);
    doWrongAddr({4'b0001, STRAP});

    // config takes first byte only, extras discarded
    doWrite(8'h01, 3, 24'h3C_77_88, "R4 cfg first byte only");
    // threshold high then low byte, third ignored
    doWrite(8'h02, 3, 24'h12_34_56, "R4 low threshold");
    // single byte to high threshold updates only bits 15:8
    doWrite(8'h03, 1, 24'hE1_00_00, "R4 high threshold one byte");
    // temperature not writable
    doWrite(8'h00, 2, 24'hFF_FF_00, "R5 temperature write ignored");

    // upper pointer bits ignored
    doWrite(8'hFE, 2, 24'h9A_BC_00, "R3 upper bits ignored");
    check("R3 low threshold via 0xFE", lowThresh, 16'h9ABC);
    doRead(5, "R6 alternating high/low");

    // config read repeats
    doPtrRead(8'h01, 3);

    // STOP in the middle of a data byte
    writeHead(8'h01);
    for (int i = 0; i < 4; i++) clockBit(i[0], s);
    busStop();
    check("R10 partial byte discarded", {8'h00, cfgOut}, {8'h00, mCfg});
    doRead(1, "R10 next transaction (R7 stored pointer)");

    // constrained random mix
    for (int it = 0; it < 28; it++) begin
      int kind = $urandom_range(0, 3);
      sensorValue = 16'($urandom);
      case (kind)
        0: doWrite({6'($urandom), 2'($urandom)}, $urandom_range(0, 3), 24'($urandom), "R4 random write");
        1: doRead($urandom_range(1, 4), "R7 random read stored pointer");
        2: doPtrRead({6'b0, 2'($urandom)}, $urandom_range(1, 4));
        default: doWrongAddr(DEV ^ {4'($urandom_range(0, 15)), 3'($urandom_range(1, 7))});
      endcase
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule